// File: doc/BRIEF.md
# Taint-Tracked Predicated Register File

This block holds eight 32-bit general registers and two one-bit predicate registers, each paired with a one-bit shadow taint flag. A taint of 1 marks a value as untrusted. Every clock cycle is one instruction. It names a destination, which is either a general register or a predicate register, and supplies a candidate value with its taint. It also picks a predicate through a two-bit selector. The selector can point at a trusted constant or at either predicate register.

The register file has no write enable. On every edge the destination takes the output of a taint-tracked two-way multiplexer. The selected predicate steers this multiplexer between the candidate and the destination's current contents. When the predicate's own taint is 1, the destination comes out tainted even if it keeps its old value. A data-dependent skip therefore shows up as explicit taint rather than leaking silently. Two combinational read ports return a general register with its taint. The predicate registers and their taints are always visible.

Top module: `pwb_regfile`

## Requirements
- R1: While `rst_n` is low, all general and predicate register values and all taints clear to 0 on the rising edge.
- R2: When the selected predicate is 1 and trusted, the destination takes `wr_val` and `wr_val_taint` at the next rising edge.
- R3: When the selected predicate is 0 and trusted, the destination keeps both its value and its taint.
- R4: Selector encoding on `wr_psel`: 0 is constant 0, 1 is constant 1, 2 is predicate register 0, 3 is predicate register 1. The constants are trusted. A predicate register supplies its stored bit and its stored taint.
- R5: When the selected predicate's taint is 1, the destination's taint becomes 1 whatever the predicate's value. Its value still follows the predicate, either the candidate or the old value.
- R6: Registers other than the destination keep their values and taints unchanged.
- R7: With `wr_is_pred` = 1, the destination is predicate register `wr_dst[0]`. Its candidate value is `wr_val[0]` and it goes through the same predicated path. No general register changes in that cycle.
- R8: Reads are combinational from the stored state. A register written in a cycle reads its pre-edge contents until that edge, with no bypass.
- R9: The two read ports are independent. Each returns the value and taint of the register its own index names.
- R10: `pred_val[k]` and `pred_taint[k]` always show predicate register k and its taint.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_is_pred | input | 1 | Destination is a predicate register when 1 |
| wr_dst | input | 3 | Destination index |
| wr_val | input | 32 | Candidate value (bit 0 for predicate destinations) |
| wr_val_taint | input | 1 | Taint of the candidate value |
| wr_psel | input | 2 | Predicate selector (R4 encoding) |
| rd_a_idx | input | 3 | Read port A index |
| rd_b_idx | input | 3 | Read port B index |
| rd_a_val | output | 32 | Read port A value |
| rd_a_taint | output | 1 | Read port A taint |
| rd_b_val | output | 32 | Read port B value |
| rd_b_taint | output | 1 | Read port B taint |
| pred_val | output | 2 | Predicate register values |
| pred_taint | output | 2 | Predicate register taints |

## Verification
A taint bit cleared wrongly inside the block is visible on a read port in the cycle right after the faulty edge, but only when that register is read. A wrong predicate decode, for example using the wrong register or treating a constant as untrusted, shows up only on the destination of the following instruction. The bench therefore chains predicate writes into guarded general writes and reads each destination on the next step. A write leaking into a register other than the destination stays invisible until that register is read. For that reason a long pseudo-random phase sweeps both read indices while it writes.

// File: rtl/pwb_pkg.sv
package pwb_pkg;

  // Selector codes of the predicate field
  localparam logic [1:0] PSEL_CONST0 = 2'd0;
  localparam logic [1:0] PSEL_CONST1 = 2'd1;
  localparam int unsigned PSEL_REG_BASE = 2;

  // Taint of a two-way select when any taint on the select line poisons the output
  function automatic logic taint_sel_safe(input logic s, input logic st,
                                          input logic nt, input logic ot);
    return st ? 1'b1 : (s ? nt : ot);
  endfunction

  // Taint of a two-way select that exempts a tainted select when both inputs agree
  function automatic logic taint_sel_exact(input logic s, input logic st,
                                           input logic nt, input logic ot,
                                           input logic differ);
    return st ? (differ | nt | ot) : (s ? nt : ot);
  endfunction

endpackage

// File: rtl/pwb_pred_decode.sv
module pwb_pred_decode #(
  parameter int NUM_PRED = 2,
  parameter int SEL_W    = 2
) (
  input  logic [SEL_W-1:0]    sel,
  input  logic [NUM_PRED-1:0] pred_q,
  input  logic [NUM_PRED-1:0] pred_t,
  output logic                p,
  output logic                pt
);
  import pwb_pkg::*;

  always_comb begin
    p  = 1'b0;
    pt = 1'b0;
    if (sel == SEL_W'(PSEL_CONST1)) p = 1'b1;
    for (int k = 0; k < NUM_PRED; k++) begin
      if (sel == SEL_W'(PSEL_REG_BASE + k)) begin
        p  = pred_q[k];
        pt = pred_t[k];
      end
    end
  end

endmodule

// File: rtl/pwb_shadow_mux.sv
module pwb_shadow_mux #(
  parameter int W       = 32,
  parameter bit PRECISE = 1'b0
) (
  input  logic         s,
  input  logic         st,
  input  logic [W-1:0] new_v,
  input  logic         new_t,
  input  logic [W-1:0] old_v,
  input  logic         old_t,
  output logic [W-1:0] out_v,
  output logic         out_t
);
  import pwb_pkg::*;

  assign out_v = s ? new_v : old_v;

  generate
    if (PRECISE) begin : g_exact
      logic differ;
      assign differ = (new_v != old_v);
      assign out_t  = taint_sel_exact(s, st, new_t, old_t, differ);
    end else begin : g_safe
      assign out_t = taint_sel_safe(s, st, new_t, old_t);
    end
  endgenerate

endmodule

// File: rtl/pwb_shadow_bank.sv
module pwb_shadow_bank #(
  parameter int N  = 8,
  parameter int W  = 32,
  parameter int IW = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hit,
  input  logic [IW-1:0]       idx,
  input  logic [W-1:0]        d_v,
  input  logic                d_t,
  output logic [N-1:0][W-1:0] q_v,
  output logic [N-1:0]        q_t
);

  always_ff @(posedge clk) begin
    for (int i = 0; i < N; i++) begin
      if (!rst_n) begin
        q_v[i] <= '0;
        q_t[i] <= 1'b0;
      end else if (hit && idx == IW'(i)) begin
        q_v[i] <= d_v;
        q_t[i] <= d_t;
      end
    end
  end

endmodule

// File: rtl/pwb_regfile.sv
module pwb_regfile #(
  parameter int NUM_GPR  = 8,
  parameter int DATA_W   = 32,
  parameter int NUM_PRED = 2,
  parameter bit PRECISE  = 1'b0,
  localparam int IDX_W   = $clog2(NUM_GPR),
  localparam int SEL_W   = $clog2(NUM_PRED + 2),
  localparam int PIDX_W  = (NUM_PRED > 1) ? $clog2(NUM_PRED) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_is_pred,
  input  logic [IDX_W-1:0]    wr_dst,
  input  logic [DATA_W-1:0]   wr_val,
  input  logic                wr_val_taint,
  input  logic [SEL_W-1:0]    wr_psel,
  input  logic [IDX_W-1:0]    rd_a_idx,
  input  logic [IDX_W-1:0]    rd_b_idx,
  output logic [DATA_W-1:0]   rd_a_val,
  output logic                rd_a_taint,
  output logic [DATA_W-1:0]   rd_b_val,
  output logic                rd_b_taint,
  output logic [NUM_PRED-1:0] pred_val,
  output logic [NUM_PRED-1:0] pred_taint
);

  // Stored state
  logic [NUM_GPR-1:0][DATA_W-1:0] gpr_q;
  logic [NUM_GPR-1:0]             gpr_t;
  logic [NUM_PRED-1:0]            pred_q;
  logic [NUM_PRED-1:0]            pred_t;

  // Named internal events
  logic               sel_p, sel_pt;
  logic [PIDX_W-1:0]  pidx;
  logic [DATA_W-1:0]  gpr_old_v, gpr_mux_v;
  logic               gpr_old_t, gpr_mux_t;
  logic               pred_old_v, pred_mux_v;
  logic               pred_old_t, pred_mux_t;
  logic               hit_gpr, hit_pred;

  assign pidx     = wr_dst[PIDX_W-1:0];
  assign hit_gpr  = !wr_is_pred;
  assign hit_pred = wr_is_pred;

  pwb_pred_decode #(.NUM_PRED(NUM_PRED), .SEL_W(SEL_W)) u_dec (
    .sel    (wr_psel),
    .pred_q (pred_q),
    .pred_t (pred_t),
    .p      (sel_p),
    .pt     (sel_pt)
  );

  assign gpr_old_v  = gpr_q[wr_dst];
  assign gpr_old_t  = gpr_t[wr_dst];
  assign pred_old_v = pred_q[pidx];
  assign pred_old_t = pred_t[pidx];

  pwb_shadow_mux #(.W(DATA_W), .PRECISE(PRECISE)) u_gmux (
    .s     (sel_p),
    .st    (sel_pt),
    .new_v (wr_val),
    .new_t (wr_val_taint),
    .old_v (gpr_old_v),
    .old_t (gpr_old_t),
    .out_v (gpr_mux_v),
    .out_t (gpr_mux_t)
  );

  pwb_shadow_mux #(.W(1), .PRECISE(PRECISE)) u_pmux (
    .s     (sel_p),
    .st    (sel_pt),
    .new_v (wr_val[0]),
    .new_t (wr_val_taint),
    .old_v (pred_old_v),
    .old_t (pred_old_t),
    .out_v (pred_mux_v),
    .out_t (pred_mux_t)
  );

  pwb_shadow_bank #(.N(NUM_GPR), .W(DATA_W), .IW(IDX_W)) u_gbank (
    .clk   (clk),
    .rst_n (rst_n),
    .hit   (hit_gpr),
    .idx   (wr_dst),
    .d_v   (gpr_mux_v),
    .d_t   (gpr_mux_t),
    .q_v   (gpr_q),
    .q_t   (gpr_t)
  );

  pwb_shadow_bank #(.N(NUM_PRED), .W(1), .IW(PIDX_W)) u_pbank (
    .clk   (clk),
    .rst_n (rst_n),
    .hit   (hit_pred),
    .idx   (pidx),
    .d_v   (pred_mux_v),
    .d_t   (pred_mux_t),
    .q_v   (pred_q),
    .q_t   (pred_t)
  );

  // Read side, straight from stored state
  assign rd_a_val   = gpr_q[rd_a_idx];
  assign rd_a_taint = gpr_t[rd_a_idx];
  assign rd_b_val   = gpr_q[rd_b_idx];
  assign rd_b_taint = gpr_t[rd_b_idx];
  assign pred_val   = pred_q;
  assign pred_taint = pred_t;

endmodule

// File: rtl/pwb_regfile_chk.sv
module pwb_regfile_chk #(
  parameter int NUM_GPR  = 8,
  parameter int DATA_W   = 32,
  parameter int NUM_PRED = 2,
  localparam int IDX_W   = $clog2(NUM_GPR),
  localparam int PIDX_W  = (NUM_PRED > 1) ? $clog2(NUM_PRED) : 1
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           wr_is_pred,
  input logic [IDX_W-1:0]               wr_dst,
  input logic [DATA_W-1:0]              wr_val,
  input logic                           wr_val_taint,
  input logic                           sel_p,
  input logic                           sel_pt,
  input logic [NUM_GPR-1:0][DATA_W-1:0] gpr_q,
  input logic [NUM_GPR-1:0]             gpr_t,
  input logic [NUM_PRED-1:0]            pred_q,
  input logic [NUM_PRED-1:0]            pred_t
);

  assert_take_new_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_is_pred && sel_p && !sel_pt) |=>
      (gpr_q[$past(wr_dst)] == $past(wr_val) && gpr_t[$past(wr_dst)] == $past(wr_val_taint)));

  assert_keep_old_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_is_pred && !sel_p && !sel_pt) |=>
      (gpr_q[$past(wr_dst)] == $past(gpr_q[wr_dst]) && gpr_t[$past(wr_dst)] == $past(gpr_t[wr_dst])));

  assert_pred_taints_gpr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_is_pred && sel_pt) |=> gpr_t[$past(wr_dst)]);

  assert_pred_taints_pred_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_is_pred && sel_pt) |=> pred_t[$past(wr_dst[PIDX_W-1:0])]);

  assert_pred_dest_new_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_is_pred && sel_p && !sel_pt) |=>
      (pred_q[$past(wr_dst[PIDX_W-1:0])] == $past(wr_val[0]) &&
       pred_t[$past(wr_dst[PIDX_W-1:0])] == $past(wr_val_taint)));

  assert_pred_dest_gpr_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_is_pred |=> ($stable(gpr_q) && $stable(gpr_t)));

  generate
    for (genvar i = 0; i < NUM_GPR; i++) begin : g_gpr_hold
      assert_untouched_gpr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_is_pred || wr_dst != IDX_W'(i)) |=> ($stable(gpr_q[i]) && $stable(gpr_t[i])));
    end
    for (genvar k = 0; k < NUM_PRED; k++) begin : g_pred_hold
      assert_untouched_pred_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_is_pred || wr_dst[PIDX_W-1:0] != PIDX_W'(k)) |=> ($stable(pred_q[k]) && $stable(pred_t[k])));
    end
  endgenerate

endmodule

bind pwb_regfile pwb_regfile_chk #(
  .NUM_GPR(NUM_GPR), .DATA_W(DATA_W), .NUM_PRED(NUM_PRED)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_is_pred(wr_is_pred), .wr_dst(wr_dst),
  .wr_val(wr_val), .wr_val_taint(wr_val_taint), .sel_p(sel_p), .sel_pt(sel_pt),
  .gpr_q(gpr_q), .gpr_t(gpr_t), .pred_q(pred_q), .pred_t(pred_t)
);

// File: tb/pwb_regfile_test.sv
module pwb_regfile_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_is_pred = 1'b0;
  logic [2:0]  wr_dst = '0;
  logic [31:0] wr_val = '0;
  logic        wr_val_taint = 1'b0;
  logic [1:0]  wr_psel = '0;
  logic [2:0]  rd_a_idx = '0;
  logic [2:0]  rd_b_idx = '0;
  logic [31:0] rd_a_val, rd_b_val;
  logic        rd_a_taint, rd_b_taint;
  logic [1:0]  pred_val, pred_taint;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // Reference state
  logic [31:0] m_v [8];
  logic        m_t [8];
  logic        m_p [2];
  logic        m_pt[2];
  logic [31:0] lfsr = 32'h1ACE_B00C;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwb_regfile uut (
    .clk(clk), .rst_n(rst_n), .wr_is_pred(wr_is_pred), .wr_dst(wr_dst),
    .wr_val(wr_val), .wr_val_taint(wr_val_taint), .wr_psel(wr_psel),
    .rd_a_idx(rd_a_idx), .rd_b_idx(rd_b_idx),
    .rd_a_val(rd_a_val), .rd_a_taint(rd_a_taint),
    .rd_b_val(rd_b_val), .rd_b_taint(rd_b_taint),
    .pred_val(pred_val), .pred_taint(pred_taint)
  );

  task automatic check(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] next_rand();
    lfsr = lfsr ^ (lfsr << 13);
    lfsr = lfsr ^ (lfsr >> 17);
    lfsr = lfsr ^ (lfsr << 5);
    return lfsr;
  endfunction

  // One instruction: drive, compare pre-edge reads, advance the model
  task automatic step(input string tag, input logic isp, input logic [2:0] dst,
                      input logic [31:0] val, input logic vt, input logic [1:0] sel,
                      input logic [2:0] ra, input logic [2:0] rb);
    logic p, pt, ov, ot;
    @(negedge clk);
    wr_is_pred = isp; wr_dst = dst; wr_val = val; wr_val_taint = vt;
    wr_psel = sel; rd_a_idx = ra; rd_b_idx = rb;
    #1;
    check(tag, "port A", {31'd0, rd_a_taint, rd_a_val}, {31'd0, m_t[ra], m_v[ra]});
    check(tag, "port B", {31'd0, rd_b_taint, rd_b_val}, {31'd0, m_t[rb], m_v[rb]});
    check(tag, "pred value", {62'd0, pred_val}, {62'd0, m_p[1], m_p[0]});
    check(tag, "pred taint", {62'd0, pred_taint}, {62'd0, m_pt[1], m_pt[0]});
    case (sel)
      2'd0: begin p = 1'b0; pt = 1'b0; end
      2'd1: begin p = 1'b1; pt = 1'b0; end
      2'd2: begin p = m_p[0]; pt = m_pt[0]; end
      default: begin p = m_p[1]; pt = m_pt[1]; end
    endcase
    if (isp) begin
      ov = m_p[dst[0]]; ot = m_pt[dst[0]];
      m_p[dst[0]]  = p ? val[0] : ov;
      m_pt[dst[0]] = pt ? 1'b1 : (p ? vt : ot);
    end else begin
      ot = m_t[dst];
      if (p) m_v[dst] = val;
      m_t[dst] = pt ? 1'b1 : (p ? vt : ot);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) begin m_v[i] = '0; m_t[i] = 1'b0; end
    for (int k = 0; k < 2; k++) begin m_p[k] = 1'b0; m_pt[k] = 1'b0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state through both ports and predicate outputs
    step("R1", 0, 3'd0, 32'd0, 0, 2'd0, 3'd0, 3'd1);
    step("R1", 0, 3'd0, 32'd0, 0, 2'd0, 3'd2, 3'd3);
    step("R1", 0, 3'd0, 32'd0, 0, 2'd0, 3'd4, 3'd5);
    step("R1", 0, 3'd0, 32'd0, 0, 2'd0, 3'd6, 3'd7);
    // R8: read r3 while it is written
    step("R8", 0, 3'd3, 32'hDEAD_BEEF, 0, 2'd1, 3'd3, 3'd3);
    // R2: new value visible; now try a constant-0 write
    step("R2", 0, 3'd3, 32'h0000_1234, 0, 2'd0, 3'd3, 3'd0);
    // R3: old value kept; set P0=1 trusted
    step("R3", 1, 3'd0, 32'd1, 0, 2'd1, 3'd3, 3'd2);
    // R7 / R10: P0 visible; write r5 guarded by P0
    step("R7", 0, 3'd5, 32'hA5A5_A5A5, 0, 2'd2, 3'd0, 3'd1);
    // R4: r5 took the value through P0; set P1=0 tainted
    step("R4", 1, 3'd1, 32'd0, 1, 2'd1, 3'd5, 3'd5);
    // R10: P1 taint visible; write r6 guarded by tainted P1 (false)
    step("R10", 0, 3'd6, 32'h0000_0777, 0, 2'd3, 3'd6, 3'd5);
    // R5: r6 still 0 but tainted; clean it with trusted constant 1
    step("R5", 0, 3'd6, 32'h0000_FFFF, 0, 2'd1, 3'd6, 3'd7);
    // R9: independent ports; predicate write guarded by tainted P1
    step("R9", 1, 3'd0, 32'd0, 0, 2'd3, 3'd6, 3'd3);
    // R5: P0 kept value 1 but now tainted; tainted data into r2
    step("R5", 0, 3'd2, 32'h0000_0042, 1, 2'd1, 3'd0, 3'd0);
    // R6: r2 tainted, r3 untouched by everything since
    step("R6", 0, 3'd0, 32'd0, 0, 2'd0, 3'd2, 3'd3);

    // R6: pseudo-random sweep
    for (int n = 0; n < 600; n++) begin
      logic [31:0] r;
      logic [31:0] v;
      r = next_rand();
      v = next_rand();
      step("R6", (r[3:0] == 4'd0), r[6:4], v, r[7] & r[8], r[10:9], r[13:11], r[16:14]);
    end
    step("R6", 0, 3'd0, 32'd0, 0, 2'd0, 3'd1, 3'd2);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule